// File: doc/BRIEF.md
# Strap-Configured Bus Slave Select and Acknowledge Decoder

This block decides whether a cycle on a parallel backplane bus is aimed at this card. It compares the address lines against a base address set by board straps, checks that the address-modifier code names the address space the card is strapped for, and checks the privilege bit against one of three strapped access modes. A cycle that matches while at least one data strobe is low selects the card. The card then captures the register index (address bits 4..1) and the write and longword qualifiers into a state register, so the host may change the bus lines for its next cycle while this one completes.

Once selected, the block produces a one-cycle write strobe a fixed number of clocks later, giving the steered data time to settle. It asserts the active-low acknowledge after a delay set in nanoseconds and converted to clock cycles. Select and acknowledge are held until both data strobes are high again, and the block re-arms on the next clock. A cycle that fails any part of the match is ignored: no select, no strobe, no acknowledge. Data steering and register contents belong to neighbouring blocks.

Top module: `bus_slave_decode`

## Requirements
- R1: While `rst_n` is low, `sel_o` is 0, `dtack_n_o` is 1 and `wr_stb_o` is 0, whatever the bus inputs are.
- R2: Strap bit `strap_base_i[k]` belongs to address bit A(k+5). A fitted strap (1) requires that address bit to be 0, and an absent strap (0) requires it to be 1. Address bits A15..A5 are always compared.
- R3: With `strap_std_i` = 0 (16-bit space), A23..A16 are ignored. With `strap_std_i` = 1 (24-bit space), A23..A16 are compared by the rule of R2.
- R4: The modifier `am_i` must carry space code `am_i[5:3]` = 3'b101 when `strap_std_i` = 0, or 3'b111 when `strap_std_i` = 1, together with `am_i[1:0]` = 2'b01. Any other code is no match.
- R5: `am_i[2]` = 1 marks a supervisory access and 0 a nonprivileged one. With `strap_any_i` = 1 both are accepted. Otherwise, with `strap_np_i` = 1 only nonprivileged accesses are accepted. With neither strap fitted, only supervisory accesses are accepted.
- R6: An idle block selects on the clock edge where the inputs match and `ds_n_i` != 2'b11. On that edge `reg_idx_o` takes A4..A1, `wr_o` takes the inverse of `write_n_i` and `lword_o` takes the inverse of `lword_n_i`. These outputs then stay unchanged until release, even if the bus lines change.
- R7: For a write, `wr_stb_o` is high for exactly the one cycle that begins WR_DLY_CYC edges after the selecting edge (default 2). For a read, it never rises.
- R8: `dtack_n_o` goes low ACK_CYC = ceil(ACK_NS*CLK_HZ/1e9) edges after the selecting edge (8 at the defaults of 150 ns and 50 MHz). It stays low until release.
- R9: When both strobes are high while selected, `sel_o` clears and `dtack_n_o` returns high on the next edge. A cycle released before ACK_CYC ends without an acknowledge. The block can select again on the edge after release.
- R10: A cycle that fails R2..R5 produces no select, no write strobe and no acknowledge, however long its strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus inputs are assumed synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 23 | Bus address lines A23..A1 |
| am_i | input | 6 | Address modifier code |
| write_n_i | input | 1 | Low for a write cycle |
| lword_n_i | input | 1 | Low for a longword transfer |
| ds_n_i | input | 2 | Active-low data strobes |
| strap_base_i | input | 19 | Base address straps for A23..A5, 1 = fitted |
| strap_std_i | input | 1 | 1 = 24-bit space, 0 = 16-bit space |
| strap_np_i | input | 1 | Nonprivileged-only strap |
| strap_any_i | input | 1 | Either-privilege strap |
| sel_o | output | 1 | Card selected |
| reg_idx_o | output | 4 | Captured register index (A4..A1) |
| wr_o | output | 1 | Captured write qualifier |
| lword_o | output | 1 | Captured longword qualifier |
| wr_stb_o | output | 1 | Delayed one-cycle write strobe |
| dtack_n_o | output | 1 | Active-low data acknowledge |

## Verification
The bench aims at single-bit address mismatches, upper address bits in both space settings, and every pairing of privilege mode and access kind. A decoder that compares the wrong group, or that reads the strap polarity backwards, would either answer for another card's address or stay silent for its own. In every selected cycle the bench changes the bus lines mid-cycle; a design that decodes the live bus instead of the captured copy would show the wrong index or direction. Aborted cycles and back-to-back cycles check that release is tied to both strobes being high, that no late acknowledge leaks out, and that re-arming takes one edge and no more.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int ADDR_LO  = 5;             // lowest compared address bit
  localparam int ADDR_HI  = 23;            // highest address bit
  localparam int STRAP_W  = ADDR_HI - ADDR_LO + 1;
  localparam int IDX_W    = 4;             // captured A4..A1
  localparam int NGRP     = 3;             // three comparator groups
  localparam int SHORT_TOP = 15;           // top bit of the 16-bit space

  // Group bounds, relative to ADDR_LO: {2:0}, {10:3}, {18:11}
  function automatic int grp_lo(input int g);
    return (g == 0) ? 0 : 8 * g - 5;
  endfunction

  function automatic int grp_hi(input int g);
    return 8 * g + 2;
  endfunction

  // Acknowledge delay in whole clock cycles, rounded up
  function automatic int ack_cycles(input longint hz, input longint ns);
    return int'((ns * hz + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  // Modifier space code and access type
  function automatic logic am_space_ok(input logic [5:0] am, input logic std);
    return (am[5:3] == (std ? 3'b111 : 3'b101)) && (am[1:0] == 2'b01);
  endfunction

  // Privilege check against strapped mode
  function automatic logic priv_ok(input logic sup, input logic np, input logic any);
    if (any) return 1'b1;
    if (np)  return !sup;
    return sup;
  endfunction
endpackage

// File: rtl/bsd_match.sv
module bsd_match
  import bsd_pkg::*;
(
  input  logic [STRAP_W-1:0] addr_hi_i,   // A23..A5
  input  logic [5:0]         am_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               std_i,
  input  logic               np_i,
  input  logic               any_i,
  output logic [NGRP-1:0]    grp_ok_o,
  output logic               hit_o
);
  logic am_ok;
  assign am_ok = am_space_ok(am_i, std_i) && priv_ok(am_i[2], np_i, any_i);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = grp_lo(g);
    localparam int HI = grp_hi(g);
    logic eq;
    assign eq = (addr_hi_i[HI:LO] == ~strap_i[HI:LO]);
    if (g == 0) begin : g_mod
      assign grp_ok_o[g] = eq && am_ok;
    end else if (LO + ADDR_LO > SHORT_TOP) begin : g_upper
      assign grp_ok_o[g] = eq || !std_i;
    end else begin : g_plain
      assign grp_ok_o[g] = eq;
    end
  end

  assign hit_o = &grp_ok_o;
endmodule

// File: rtl/bsd_timer.sv
module bsd_timer #(
  parameter int ACK_CYC    = 8,
  parameter int WR_DLY_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic wr_phase_o,
  output logic ack_o
);
  localparam int CNT_W = $clog2(ACK_CYC + 1);
  localparam logic [CNT_W-1:0] ACK_V = CNT_W'(ACK_CYC);
  localparam logic [CNT_W-1:0] WR_V  = CNT_W'(WR_DLY_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != ACK_V) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wr_phase_o = run_i && (cnt_q == WR_V);
  assign ack_o      = run_i && (cnt_q == ACK_V);
endmodule

// File: rtl/bus_slave_decode.sv
module bus_slave_decode
  import bsd_pkg::*;
#(
  parameter longint CLK_HZ     = 50_000_000,
  parameter longint ACK_NS     = 150,
  parameter int     WR_DLY_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_HI:1]     addr_i,
  input  logic [5:0]           am_i,
  input  logic                 write_n_i,
  input  logic                 lword_n_i,
  input  logic [1:0]           ds_n_i,
  input  logic [STRAP_W-1:0]   strap_base_i,
  input  logic                 strap_std_i,
  input  logic                 strap_np_i,
  input  logic                 strap_any_i,
  output logic                 sel_o,
  output logic [IDX_W-1:0]     reg_idx_o,
  output logic                 wr_o,
  output logic                 lword_o,
  output logic                 wr_stb_o,
  output logic                 dtack_n_o
);
  localparam int ACK_CYC = ack_cycles(CLK_HZ, ACK_NS);

  logic            hit;
  logic [NGRP-1:0] grp_ok;
  logic            strobe_any;
  logic            strobe_none;
  logic            take;
  logic            sel_q, wr_q, lw_q;
  logic [IDX_W-1:0] idx_q;
  logic            wr_phase, ack;

  bsd_match u_match (
    .addr_hi_i (addr_i[ADDR_HI:ADDR_LO]),
    .am_i      (am_i),
    .strap_i   (strap_base_i),
    .std_i     (strap_std_i),
    .np_i      (strap_np_i),
    .any_i     (strap_any_i),
    .grp_ok_o  (grp_ok),
    .hit_o     (hit)
  );

  assign strobe_any  = (ds_n_i != 2'b11);
  assign strobe_none = (ds_n_i == 2'b11);
  assign take        = !sel_q && strobe_any && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      idx_q <= '0;
      wr_q  <= 1'b0;
      lw_q  <= 1'b0;
    end else if (take) begin
      sel_q <= 1'b1;
      idx_q <= addr_i[IDX_W:1];
      wr_q  <= !write_n_i;
      lw_q  <= !lword_n_i;
    end else if (sel_q && strobe_none) begin
      sel_q <= 1'b0;
    end
  end

  bsd_timer #(
    .ACK_CYC    (ACK_CYC),
    .WR_DLY_CYC (WR_DLY_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (sel_q),
    .wr_phase_o (wr_phase),
    .ack_o      (ack)
  );

  assign sel_o     = sel_q;
  assign reg_idx_o = idx_q;
  assign wr_o      = wr_q;
  assign lword_o   = lw_q;
  assign wr_stb_o  = wr_phase && wr_q;
  assign dtack_n_o = !ack;
endmodule

// File: rtl/bsd_chk.sv
module bsd_chk
  import bsd_pkg::*;
#(
  parameter longint CLK_HZ     = 50_000_000,
  parameter longint ACK_NS     = 150,
  parameter int     WR_DLY_CYC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       ds_n_i,
  input logic             sel_o,
  input logic [IDX_W-1:0] reg_idx_o,
  input logic             wr_o,
  input logic             lword_o,
  input logic             wr_stb_o,
  input logic             dtack_n_o
);
  localparam int ACK_CYC = ack_cycles(CLK_HZ, ACK_NS);
  localparam int CNT_W   = $clog2(ACK_CYC + 2);
  localparam logic [CNT_W-1:0] ACK_V = CNT_W'(ACK_CYC);
  localparam logic [CNT_W-1:0] WR_V  = CNT_W'(WR_DLY_CYC);

  // Cycles elapsed since select, saturating just past the ack point
  logic [CNT_W-1:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !sel_o) since_q <= '0;
    else if (since_q <= ACK_V) since_q <= since_q + 1'b1;
  end

  // R1: quiet outputs in reset
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!sel_o && dtack_n_o && !wr_stb_o);
  end

  a_r8_ack_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n_o |-> (sel_o && since_q >= ACK_V));

  a_r8_ack_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o && since_q >= ACK_V) |-> !dtack_n_o);

  a_r7_strobe_slot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (sel_o && wr_o && since_q == WR_V));

  a_r6_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o && $past(sel_o)) |-> ($stable(reg_idx_o) && $stable(wr_o) && $stable(lword_o)));

  a_r6_select_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_o) |-> ($past(ds_n_i) != 2'b11));

  a_r9_release_on_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_o) |-> ($past(ds_n_i) == 2'b11));

  a_r9_hold_while_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o && ds_n_i != 2'b11) |=> sel_o);
endmodule

bind bus_slave_decode bsd_chk #(
  .CLK_HZ     (CLK_HZ),
  .ACK_NS     (ACK_NS),
  .WR_DLY_CYC (WR_DLY_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ds_n_i    (ds_n_i),
  .sel_o     (sel_o),
  .reg_idx_o (reg_idx_o),
  .wr_o      (wr_o),
  .lword_o   (lword_o),
  .wr_stb_o  (wr_stb_o),
  .dtack_n_o (dtack_n_o)
);

// File: tb/bus_slave_decode_tb.sv
module bus_slave_decode_tb;
  localparam int HOLD   = 10;
  localparam int WR_DLY = 2;
  localparam longint HZ = 50_000_000;
  localparam int ACK    = int'((150 * HZ + 999_999_999) / 1_000_000_000);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:1] addr_i = '0;
  logic [5:0]  am_i = '0;
  logic        write_n_i = 1'b1, lword_n_i = 1'b1;
  logic [1:0]  ds_n_i = 2'b11;
  logic [18:0] strap_base_i = '0;
  logic        strap_std_i = 1'b0, strap_np_i = 1'b0, strap_any_i = 1'b0;
  logic        sel_o, wr_o, lword_o, wr_stb_o, dtack_n_o;
  logic [3:0]  reg_idx_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  bus_slave_decode u_dut (
    .clk, .rst_n, .addr_i, .am_i, .write_n_i, .lword_n_i, .ds_n_i,
    .strap_base_i, .strap_std_i, .strap_np_i, .strap_any_i,
    .sel_o, .reg_idx_o, .wr_o, .lword_o, .wr_stb_o, .dtack_n_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected match, bit by bit from the requirements (R2..R5)
  function automatic bit exp_hit(input logic [23:1] a, input logic [5:0] m,
                                 input logic [18:0] s, input bit std,
                                 input bit np, input bit any);
    bit ok = 1'b1;
    for (int b = 5; b <= 23; b++)
      if ((b <= 15 || std) && (a[b] != !s[b-5])) ok = 1'b0;
    if (m[1:0] != 2'b01) ok = 1'b0;
    if (m[5:3] != (std ? 3'b111 : 3'b101)) ok = 1'b0;
    if (!any) begin
      if (np && m[2]) ok = 1'b0;
      if (!np && !m[2]) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [23:1] own_addr(input logic [18:0] s, input bit std);
    logic [23:1] a = 23'($urandom);
    a[15:5] = ~s[10:0];
    if (std) a[23:16] = ~s[18:11];
    return a;
  endfunction

  function automatic logic [5:0] good_am(input bit std, input bit sup);
    return {(std ? 3'b111 : 3'b101), sup, 2'b01};
  endfunction

  // One bus cycle; called at a negedge, returns at a negedge with strobes high
  task automatic run_cycle(input logic [23:1] a, input logic [5:0] m,
                           input bit wr, input bit lw, input logic [1:0] dsn,
                           input int abort_at);
    bit exp;
    addr_i = a; am_i = m; write_n_i = !wr; lword_n_i = !lw; ds_n_i = dsn;
    exp = exp_hit(a, m, strap_base_i, strap_std_i, strap_np_i, strap_any_i);
    for (int k = 0; k < HOLD; k++) begin
      @(negedge clk);
      if (exp) begin
        chk(sel_o == 1'b1, "R6", "sel", sel_o, 1);
        chk(reg_idx_o == a[4:1], "R6", "reg_idx", reg_idx_o, a[4:1]);
        chk(wr_o == wr, "R6", "wr", wr_o, wr);
        chk(lword_o == lw, "R6", "lword", lword_o, lw);
        chk(wr_stb_o == (wr && k == WR_DLY), "R7", "wr_stb", wr_stb_o, (wr && k == WR_DLY));
        chk(dtack_n_o == (k < ACK), "R8", "dtack_n", dtack_n_o, (k < ACK));
        if (k == 3) begin  // R6: bus lines change, captured copy must not
          addr_i = 23'($urandom); write_n_i = !write_n_i; lword_n_i = !lword_n_i;
        end
      end else begin
        chk(sel_o == 1'b0, "R10", "sel", sel_o, 0);
        chk(dtack_n_o == 1'b1, "R10", "dtack_n", dtack_n_o, 1);
        chk(wr_stb_o == 1'b0, "R10", "wr_stb", wr_stb_o, 0);
      end
      if (k == abort_at) break;
    end
    ds_n_i = 2'b11;
    @(negedge clk);
    chk(sel_o == 1'b0, "R9", "sel after release", sel_o, 0);
    chk(dtack_n_o == 1'b1, "R9", "dtack_n after release", dtack_n_o, 1);
    chk(wr_stb_o == 1'b0, "R9", "wr_stb after release", wr_stb_o, 0);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [23:1] a;
    void'($urandom(32'h5EED_0042));
    // R1: reset holds outputs quiet even with a matching strobed cycle
    strap_base_i = 19'h0_5A3C; strap_std_i = 1'b0; strap_any_i = 1'b1;
    addr_i = own_addr(strap_base_i, 1'b0); am_i = good_am(1'b0, 1'b1);
    write_n_i = 1'b0; ds_n_i = 2'b00;
    repeat (3) @(negedge clk);
    chk(sel_o == 1'b0, "R1", "sel in reset", sel_o, 0);
    chk(dtack_n_o == 1'b1, "R1", "dtack_n in reset", dtack_n_o, 1);
    chk(wr_stb_o == 1'b0, "R1", "wr_stb in reset", wr_stb_o, 0);
    ds_n_i = 2'b11;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R2/R6/R7/R8: plain write then back-to-back read (R9 re-arm)
    a = own_addr(strap_base_i, 1'b0);
    run_cycle(a, good_am(1'b0, 1'b0), 1'b1, 1'b0, 2'b00, -1);
    run_cycle(a ^ 23'h0000F, good_am(1'b0, 1'b1), 1'b0, 1'b1, 2'b10, -1);
    // R2: single bit off at A5 and at A15
    run_cycle(a ^ 23'h0000010, good_am(1'b0, 1'b1), 1'b1, 1'b0, 2'b00, -1);
    run_cycle(a ^ (23'h1 << 14), good_am(1'b0, 1'b1), 1'b1, 1'b0, 2'b01, -1);
    // R3: upper bits ignored in 16-bit space, compared in 24-bit space
    a[23:16] = ~a[23:16];
    run_cycle(a, good_am(1'b0, 1'b1), 1'b0, 1'b0, 2'b00, -1);
    strap_std_i = 1'b1;
    a = own_addr(strap_base_i, 1'b1);
    run_cycle(a, good_am(1'b1, 1'b1), 1'b1, 1'b1, 2'b00, -1);
    run_cycle(a ^ (23'h1 << 22), good_am(1'b1, 1'b1), 1'b1, 1'b1, 2'b00, -1);
    // R4: wrong space code and wrong low modifier bits
    run_cycle(a, good_am(1'b0, 1'b1), 1'b1, 1'b0, 2'b00, -1);
    run_cycle(a, {3'b111, 1'b1, 2'b10}, 1'b1, 1'b0, 2'b00, -1);
    // R5: three privilege modes against both access kinds
    strap_any_i = 1'b0; strap_np_i = 1'b0;
    run_cycle(a, good_am(1'b1, 1'b1), 1'b0, 1'b0, 2'b00, -1);
    run_cycle(a, good_am(1'b1, 1'b0), 1'b0, 1'b0, 2'b00, -1);
    strap_np_i = 1'b1;
    run_cycle(a, good_am(1'b1, 1'b1), 1'b0, 1'b0, 2'b00, -1);
    run_cycle(a, good_am(1'b1, 1'b0), 1'b1, 1'b0, 2'b00, -1);
    strap_any_i = 1'b1;
    run_cycle(a, good_am(1'b1, 1'b1), 1'b1, 1'b0, 2'b00, -1);
    // R9: abort before the acknowledge, then a full cycle right after
    run_cycle(a, good_am(1'b1, 1'b1), 1'b1, 1'b0, 2'b00, 4);
    run_cycle(a, good_am(1'b1, 1'b0), 1'b0, 1'b1, 2'b00, -1);
    // R10: strobes held with no strobe-released select for a long stretch
    run_cycle(a ^ 23'h0000020, good_am(1'b1, 1'b1), 1'b1, 1'b0, 2'b00, -1);

    // Random cycles under random strap settings
    for (int i = 0; i < 80; i++) begin
      logic [5:0] m;
      if (i % 10 == 0) begin
        strap_base_i = 19'($urandom);
        strap_std_i  = 1'($urandom);
        strap_np_i   = 1'($urandom);
        strap_any_i  = 1'($urandom);
      end
      if ($urandom % 3 != 0) begin
        a = own_addr(strap_base_i, strap_std_i);
        m = good_am(strap_std_i, 1'($urandom));
      end else begin
        a = 23'($urandom);
        m = 6'($urandom);
      end
      run_cycle(a, m, 1'($urandom), 1'($urandom), 2'($urandom % 3),
                ($urandom % 4 == 0) ? int'($urandom % 8) : -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule